// File: doc/BRIEF.md
# Scratchpad Memory Command Processor

This block is the byte-level engine behind the memory-function layer of a single-wire serial EEPROM slave. A transport layer below it handles bit timing. It hands this engine each byte the master writes with a one-cycle `rx_valid` strobe. It asks for each byte the master reads with a one-cycle `tx_req`. The engine answers every `tx_req` one cycle later with `tx_ack` and `tx_byte`.

The engine holds a 16-bit target address, a 3-bit ending offset, an access-accepted flag, an 8-byte scratchpad and a 144-byte memory built from registers. Three command codes are decoded:
- `AAh` returns the address, the status byte, the addressed scratchpad bytes and an inverted CRC-16.
- `55h` checks a 3-byte echo of the address and status, then copies the scratchpad into a memory row.
- `F0h` streams memory from a master-supplied address.

The write-scratchpad stage is outside this block. It deposits its result through the staging port. A bus reset sends the engine back to waiting for a command.

Top module: `spm_cmd_engine`

## Requirements
- R1: After reset, and in command-wait, every read byte is FFh. `tx_ack` pulses exactly one cycle after each `tx_req`, with `tx_byte` valid in that cycle.
- R2: After command AAh, the first three read bytes are the target address low byte, the target address high byte, and the status byte. The status byte carries bit 7 = accepted flag, bit 5 = `pf_flag`, bits 2:0 = ending offset, and all other bits zero.
- R3: After those three bytes, AAh returns ((ending offset − target[2:0]) mod 8) + 1 scratchpad bytes. They start at scratchpad index target[2:0] and the index increments modulo 8.
- R4: After the scratchpad bytes, AAh sends the bitwise inverse of a CRC-16 (reflected polynomial A001h, seed 0000h, bits taken LSB first), low byte first. The CRC covers the command byte and every byte sent before it. Every later read is FFh.
- R5: For command 55h, the master sends three bytes. If they equal address low, address high and status, and the copy is allowed, reads return 00h for PROG_CYCLES cycles. After that, the scratchpad is in the 8-byte row (target with bits 2:0 cleared), the accepted flag (status bit 7) is 1, and reads return AAh until a bus reset.
- R6: If any of the three 55h bytes differs, no memory byte changes, the accepted flag stays 0, and reads return FFh.
- R7: A matching 55h is also refused (as in R6) when `pf_flag` is 1, when the target is above 008Fh, or when `protect_mask[target/32]` is 1.
- R8: For command F0h, the next two bytes (low, high) form an address. Each read returns the memory byte at that address and advances it. Addresses above 008Fh read FFh.
- R9: An F0h command leaves the target address, status byte and scratchpad unchanged.
- R10: `bus_reset` abandons any command in progress; the next received byte is decoded as a command.
- R11: An unknown command code makes every following read FFh until a bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | Return to command-wait |
| rx_valid | input | 1 | Byte from master present |
| rx_byte | input | 8 | Byte from master |
| tx_req | input | 1 | Master reads one byte |
| tx_ack | output | 1 | Answer to tx_req, one cycle later |
| tx_byte | output | 8 | Byte to master, valid with tx_ack |
| pf_flag | input | 1 | Power-fail flag, blocks copies |
| protect_mask | input | NPAGES | Per-32-byte-page copy protection |
| stage_we | input | 1 | Load scratchpad state, clears accepted flag |
| stage_ta | input | 16 | Target address to load |
| stage_eoff | input | 3 | Ending offset to load |
| stage_data | input | 64 | Scratchpad bytes, byte i in bits 8i+7:8i |

## Verification
A received byte is acted on at the next edge. A read byte is registered at the edge after `tx_req`, so the bench raises each strobe on a falling edge and samples `tx_ack`/`tx_byte` on the following falling edge. The copy result is judged at two points. The first is a read taken a few cycles after the last echo byte, which must fall inside the busy window. The second is a read taken more than PROG_CYCLES cycles later. Memory and flag effects of a copy are observed only afterwards, through F0h and AAh reads.

// File: rtl/spm_pkg.sv
// Shared types and constants of the scratchpad command engine.
// Assumes byte-wide transport and a reflected CRC-16 (A001h) sent LSB first.
package spm_pkg;

    typedef enum logic [2:0] {
        S_CMD,      // waiting for a command byte
        S_RDSP,     // streaming scratchpad read
        S_CP_AUTH,  // collecting the 3-byte echo
        S_CP_BUSY,  // programming window
        S_CP_DONE,  // copy finished, alternating pattern
        S_IGNORE,   // refused or unknown, fill bytes only
        S_RM_ADDR,  // collecting the memory address
        S_RM_DATA   // streaming memory read
    } eng_state_t;

    localparam logic [7:0] CMD_READ_SP  = 8'hAA;
    localparam logic [7:0] CMD_COPY_SP  = 8'h55;
    localparam logic [7:0] CMD_READ_MEM = 8'hF0;
    localparam logic [7:0] FILL_BYTE    = 8'hFF;
    localparam logic [7:0] BUSY_BYTE    = 8'h00;
    localparam logic [7:0] DONE_BYTE    = 8'hAA;

    // One byte of the reflected CRC-16, LSB of the data first.
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/spm_crc16.sv
// CRC-16 accumulator. seed restarts it from zero with din folded in;
// step folds din into the running value. Assumes seed and step are exclusive.
module spm_crc16
    import spm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        seed,
    input  logic        step,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    logic [15:0] crc_q;

    // Holds the running CRC value.
    always_ff @(posedge clk) begin
        if (!rst_n)    crc_q <= 16'h0000;
        else if (seed) crc_q <= crc16_step(16'h0000, din);
        else if (step) crc_q <= crc16_step(crc_q, din);
    end

    assign crc = crc_q;

endmodule

// File: rtl/spm_copy_gate.sv
// Copy permission: echo matched, target in range, no power-fail, page unlocked.
// Assumes pages of PAGE_BYTES starting at address 0. Purely combinational.
module spm_copy_gate #(
    parameter int MEM_BYTES  = 144,
    parameter int PAGE_BYTES = 32,
    parameter int NPAGES     = (MEM_BYTES + PAGE_BYTES - 1) / PAGE_BYTES
) (
    input  logic [15:0]       target,
    input  logic              pattern_ok,
    input  logic              pf,
    input  logic [NPAGES-1:0] protect,
    output logic              grant
);

    localparam int PG_SHIFT = $clog2(PAGE_BYTES);

    logic        in_range;
    logic        locked;
    logic [15:0] page_idx;

    assign in_range = target <= 16'(MEM_BYTES - 1);
    assign page_idx = target >> PG_SHIFT;

    // Looks up the protect bit of the page holding the target.
    always_comb begin
        locked = 1'b0;
        for (int p = 0; p < NPAGES; p++) begin
            if (page_idx == 16'(p) && protect[p]) locked = 1'b1;
        end
    end

    assign grant = pattern_ok && in_range && !pf && !locked;

endmodule

// File: rtl/spm_mem_array.sv
// Register-built memory written one row of ROW_BYTES at a time, read one
// byte combinationally. Resets to FFh (erased). Out-of-range reads give FFh.
module spm_mem_array #(
    parameter int MEM_BYTES = 144,
    parameter int ROW_BYTES = 8,
    parameter int AW        = $clog2(MEM_BYTES),
    parameter int ROW_W     = AW - $clog2(ROW_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [ROW_W-1:0]       wrow,
    input  logic [ROW_BYTES*8-1:0] wdata,
    input  logic [AW-1:0]          raddr,
    output logic [7:0]             rdata
);

    localparam int ROWS     = MEM_BYTES / ROW_BYTES;
    localparam int RB_SHIFT = $clog2(ROW_BYTES);

    logic [ROW_BYTES*8-1:0] rows [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [ROW_BYTES*8-1:0] row_q;
        // Stores one row; rewritten as a whole on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)                          row_q <= '1;
            else if (we && wrow == ROW_W'(r))    row_q <= wdata;
        end
        assign rows[r] = row_q;
    end

    logic [ROW_W-1:0]    rsel;
    logic [RB_SHIFT-1:0] bsel;
    assign rsel = raddr[AW-1:RB_SHIFT];
    assign bsel = raddr[RB_SHIFT-1:0];

    // Selects the addressed byte or the fill value.
    always_comb begin
        rdata = 8'hFF;
        if (32'(rsel) < ROWS) rdata = rows[rsel][bsel*8 +: 8];
    end

endmodule

// File: rtl/spm_cmd_engine.sv
// Memory-function command engine of a single-wire EEPROM slave.
// Decodes scratchpad read, scratchpad copy and memory read; answers every
// tx_req one cycle later. Assumes the transport never raises rx_valid and
// tx_req together, and that the staging port is used outside commands.
module spm_cmd_engine
    import spm_pkg::*;
#(
    parameter int MEM_BYTES   = 144,
    parameter int SP_BYTES    = 8,
    parameter int PAGE_BYTES  = 32,
    parameter int PROG_CYCLES = 40,
    localparam int NPAGES     = (MEM_BYTES + PAGE_BYTES - 1) / PAGE_BYTES,
    localparam int SPW        = $clog2(SP_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_reset,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_byte,
    input  logic                  tx_req,
    output logic                  tx_ack,
    output logic [7:0]            tx_byte,
    input  logic                  pf_flag,
    input  logic [NPAGES-1:0]     protect_mask,
    input  logic                  stage_we,
    input  logic [15:0]           stage_ta,
    input  logic [SPW-1:0]        stage_eoff,
    input  logic [SP_BYTES*8-1:0] stage_data
);

    localparam int AW    = $clog2(MEM_BYTES);
    localparam int ROW_W = AW - SPW;
    localparam int IDX_W = $clog2(SP_BYTES + 6);
    localparam int BW    = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
    localparam logic [15:0] LAST_ADDR = 16'(MEM_BYTES - 1);

    eng_state_t                 st;
    logic [15:0]                ta_q;
    logic [SPW-1:0]             eoff_q;
    logic [SP_BYTES-1:0][7:0]   sp_q;
    logic                       aa_q;
    logic [1:0]                 rcnt;
    logic                       auth_bad;
    logic                       grant_q;
    logic [IDX_W-1:0]           idx;
    logic [15:0]                rm_addr;
    logic [BW-1:0]              busy_cnt;

    logic [7:0]     es_byte;
    logic [SPW-1:0] span;
    logic [SPW:0]   n_sp;
    logic [IDX_W-1:0] crc_pos;
    logic [SPW-1:0] sp_off;
    logic [7:0]     tx_next;
    logic [7:0]     exp_auth;
    logic           pattern_ok;
    logic           grant;
    logic           mem_we;
    logic [7:0]     mem_rdata;
    logic [15:0]    crc;
    logic           crc_seed;
    logic           crc_step;

    assign es_byte = {aa_q, 1'b0, pf_flag, 5'(eoff_q)};
    assign span    = eoff_q - ta_q[SPW-1:0];
    assign n_sp    = {1'b0, span} + (SPW+1)'(1);
    assign crc_pos = IDX_W'(n_sp) + IDX_W'(3);
    assign sp_off  = ta_q[SPW-1:0] + SPW'(idx - IDX_W'(3));

    // Picks the byte answered to the next read request.
    always_comb begin
        tx_next = FILL_BYTE;
        unique case (st)
            S_RDSP: begin
                if (idx == IDX_W'(0))                tx_next = ta_q[7:0];
                else if (idx == IDX_W'(1))           tx_next = ta_q[15:8];
                else if (idx == IDX_W'(2))           tx_next = es_byte;
                else if (idx < crc_pos)              tx_next = sp_q[sp_off];
                else if (idx == crc_pos)             tx_next = ~crc[7:0];
                else if (idx == crc_pos + IDX_W'(1)) tx_next = ~crc[15:8];
            end
            S_CP_BUSY: tx_next = BUSY_BYTE;
            S_CP_DONE: tx_next = DONE_BYTE;
            S_RM_DATA: tx_next = (rm_addr <= LAST_ADDR) ? mem_rdata : FILL_BYTE;
            default:   tx_next = FILL_BYTE;
        endcase
    end

    // Expected echo byte for the current position of the copy handshake.
    always_comb begin
        unique case (rcnt)
            2'd0:    exp_auth = ta_q[7:0];
            2'd1:    exp_auth = ta_q[15:8];
            default: exp_auth = es_byte;
        endcase
    end

    assign pattern_ok = !auth_bad && (rx_byte == exp_auth);
    assign mem_we     = (st == S_CP_BUSY) && (busy_cnt == BW'(PROG_CYCLES - 1)) && !bus_reset;
    assign crc_seed   = (st == S_CMD) && rx_valid && !bus_reset;
    assign crc_step   = (st == S_RDSP) && tx_req && !bus_reset && (idx < crc_pos);

    spm_crc16 i_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .seed  (crc_seed),
        .step  (crc_step),
        .din   (crc_seed ? rx_byte : tx_next),
        .crc   (crc)
    );

    spm_copy_gate #(
        .MEM_BYTES  (MEM_BYTES),
        .PAGE_BYTES (PAGE_BYTES),
        .NPAGES     (NPAGES)
    ) i_gate (
        .target     (ta_q),
        .pattern_ok (pattern_ok),
        .pf         (pf_flag),
        .protect    (protect_mask),
        .grant      (grant)
    );

    spm_mem_array #(
        .MEM_BYTES (MEM_BYTES),
        .ROW_BYTES (SP_BYTES),
        .AW        (AW),
        .ROW_W     (ROW_W)
    ) i_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .wrow  (ta_q[AW-1:SPW]),
        .wdata (sp_q),
        .raddr (rm_addr[AW-1:0]),
        .rdata (mem_rdata)
    );

    // Command sequencer: decode, byte positions and programming window.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset) begin
            st       <= S_CMD;
            rcnt     <= '0;
            auth_bad <= 1'b0;
            grant_q  <= 1'b0;
            idx      <= '0;
            rm_addr  <= '0;
            busy_cnt <= '0;
        end else begin
            unique case (st)
                S_CMD: if (rx_valid) begin
                    rcnt     <= '0;
                    auth_bad <= 1'b0;
                    grant_q  <= 1'b0;
                    idx      <= '0;
                    if (rx_byte == CMD_READ_SP)       st <= S_RDSP;
                    else if (rx_byte == CMD_COPY_SP)  st <= S_CP_AUTH;
                    else if (rx_byte == CMD_READ_MEM) st <= S_RM_ADDR;
                    else                              st <= S_IGNORE;
                end
                S_RDSP: if (tx_req && idx != '1) idx <= idx + IDX_W'(1);
                S_CP_AUTH: if (rx_valid) begin
                    if (rcnt == 2'd2) begin
                        grant_q  <= grant;
                        busy_cnt <= '0;
                        st       <= grant ? S_CP_BUSY : S_IGNORE;
                    end else begin
                        rcnt     <= rcnt + 2'd1;
                        auth_bad <= auth_bad | (rx_byte != exp_auth);
                    end
                end
                S_CP_BUSY: begin
                    if (busy_cnt == BW'(PROG_CYCLES - 1)) st <= S_CP_DONE;
                    else                                  busy_cnt <= busy_cnt + BW'(1);
                end
                S_RM_ADDR: if (rx_valid) begin
                    if (rcnt == 2'd0) begin
                        rm_addr[7:0] <= rx_byte;
                        rcnt         <= 2'd1;
                    end else begin
                        rm_addr[15:8] <= rx_byte;
                        st            <= S_RM_DATA;
                    end
                end
                S_RM_DATA: if (tx_req && rm_addr != 16'hFFFF) rm_addr <= rm_addr + 16'd1;
                default: ;
            endcase
        end
    end

    // Scratchpad state: loaded by staging, accepted flag set by a finished copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ta_q   <= '0;
            eoff_q <= '0;
            sp_q   <= '0;
            aa_q   <= 1'b0;
        end else if (stage_we) begin
            ta_q   <= stage_ta;
            eoff_q <= stage_eoff;
            sp_q   <= stage_data;
            aa_q   <= 1'b0;
        end else if (mem_we) begin
            aa_q   <= 1'b1;
        end
    end

    // Read answer register, one cycle behind the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_ack  <= 1'b0;
            tx_byte <= FILL_BYTE;
        end else begin
            tx_ack <= tx_req;
            if (tx_req) tx_byte <= tx_next;
        end
    end

    AST_TX_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) tx_req |=> tx_ack); // R1
    AST_FILL_AFTER_CRC: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RDSP && tx_req && !bus_reset && idx > crc_pos + IDX_W'(1)) |=> tx_byte == 8'hFF); // R4
    AST_BUSY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_CP_BUSY && tx_req) |=> tx_byte == 8'h00); // R5
    AST_AA_ONLY_FROM_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aa_q) |-> $past(st) == S_CP_BUSY); // R5
    AST_WRITE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> grant_q); // R7
    AST_RDMEM_KEEPS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RM_DATA && !stage_we) |=> $stable(ta_q) && $stable(eoff_q) && $stable(sp_q)); // R9
    AST_RESET_TO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> st == S_CMD); // R10

endmodule

// File: tb/test_spm_cmd_engine.sv
// Directed bench: one task per scenario, each checking its own results.
module test_spm_cmd_engine;

    localparam int PROG = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_reset = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        tx_req = 1'b0;
    logic        tx_ack;
    logic [7:0]  tx_byte;
    logic        pf_flag = 1'b0;
    logic [4:0]  protect_mask = 5'b0;
    logic        stage_we = 1'b0;
    logic [15:0] stage_ta = 16'h0;
    logic [2:0]  stage_eoff = 3'd0;
    logic [63:0] stage_data = 64'h0;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    spm_cmd_engine #(.PROG_CYCLES(PROG)) i_spm_cmd_engine (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_req(tx_req), .tx_ack(tx_ack), .tx_byte(tx_byte),
        .pf_flag(pf_flag), .protect_mask(protect_mask),
        .stage_we(stage_we), .stage_ta(stage_ta), .stage_eoff(stage_eoff),
        .stage_data(stage_data)
    );

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb;
            fb = r[0] ^ d[i];
            r = {1'b0, r[15:1]};
            if (fb) r = r ^ 16'hA001;
        end
        return r;
    endfunction

    function automatic logic [63:0] mk_data(input logic [7:0] seed);
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = seed + 8'(i * 17);
        return v;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic fetch(output logic [7:0] b);
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
        chk(tx_ack === 1'b1, "R1 ack", {15'b0, tx_ack}, 16'h1);
        b = tx_byte;
    endtask

    task automatic expect_byte(input logic [7:0] exp, input string tag);
        logic [7:0] b;
        fetch(b);
        chk(b === exp, tag, {8'h0, b}, {8'h0, exp});
    endtask

    task automatic bus_rst;
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
    endtask

    task automatic stage(input logic [15:0] ta, input logic [2:0] eoff, input logic [63:0] d);
        @(negedge clk); stage_we = 1'b1; stage_ta = ta; stage_eoff = eoff; stage_data = d;
        @(negedge clk); stage_we = 1'b0;
    endtask

    // Full AAh read with model-computed bytes (R2, R3, R4).
    task automatic read_sp(input logic [15:0] ta, input logic [2:0] eoff, input logic [63:0] d,
                           input logic aa, input logic pf);
        logic [15:0] c;
        logic [7:0]  es, b;
        int n;
        bus_rst();
        send(8'hAA);
        c  = ref_crc(16'h0, 8'hAA);
        es = {aa, 1'b0, pf, 2'b00, eoff};
        expect_byte(ta[7:0], "R2 ta low");   c = ref_crc(c, ta[7:0]);
        expect_byte(ta[15:8], "R2 ta high"); c = ref_crc(c, ta[15:8]);
        expect_byte(es, "R2 status");        c = ref_crc(c, es);
        n = int'(3'(eoff - ta[2:0])) + 1;
        for (int k = 0; k < n; k++) begin
            logic [2:0] p;
            p = 3'(ta[2:0] + 3'(k));
            b = d[p*8 +: 8];
            expect_byte(b, "R3 scratchpad byte");
            c = ref_crc(c, b);
        end
        expect_byte(~c[7:0], "R4 crc low");
        expect_byte(~c[15:8], "R4 crc high");
        expect_byte(8'hFF, "R4 fill 1");
        expect_byte(8'hFF, "R4 fill 2");
    endtask

    task automatic start_copy(input logic [15:0] ta, input logic [7:0] es);
        bus_rst();
        send(8'h55); send(ta[7:0]); send(ta[15:8]); send(es);
    endtask

    task automatic t_reset;
        expect_byte(8'hFF, "R1 reset read");
    endtask

    task automatic t_rdsp;
        stage(16'h0010, 3'd7, mk_data(8'h31));
        read_sp(16'h0010, 3'd7, mk_data(8'h31), 1'b0, 1'b0);
        pf_flag = 1'b1;
        stage(16'h0085, 3'd6, mk_data(8'h52));
        read_sp(16'h0085, 3'd6, mk_data(8'h52), 1'b0, 1'b1);
        pf_flag = 1'b0;
    endtask

    task automatic t_copy_ok(input logic [15:0] ta, input logic [7:0] seed);
        stage(ta, 3'd7, mk_data(seed));
        start_copy(ta, 8'h07);
        expect_byte(8'h00, "R5 busy read");
        repeat (PROG + 5) @(negedge clk);
        expect_byte(8'hAA, "R5 done pattern 1");
        expect_byte(8'hAA, "R5 done pattern 2");
        bus_rst();
        send(8'hF0); send(ta[7:0]); send(ta[15:8]);
        for (int k = 0; k < 8; k++) begin
            logic [63:0] d;
            d = mk_data(seed);
            expect_byte(d[k*8 +: 8], "R5 copied row");
        end
        read_sp(ta, 3'd7, mk_data(seed), 1'b1, 1'b0);
    endtask

    task automatic t_copy_mismatch;
        stage(16'h0020, 3'd7, mk_data(8'h11));
        start_copy(16'h0020, 8'h06);
        expect_byte(8'hFF, "R6 refused read");
        repeat (PROG + 5) @(negedge clk);
        expect_byte(8'hFF, "R6 refused later");
        bus_rst();
        send(8'hF0); send(8'h20); send(8'h00);
        expect_byte(8'hFF, "R6 memory untouched");
        read_sp(16'h0020, 3'd7, mk_data(8'h11), 1'b0, 1'b0);
    endtask

    task automatic t_copy_denied;
        pf_flag = 1'b1;
        stage(16'h0028, 3'd7, mk_data(8'h44));
        start_copy(16'h0028, 8'h27);
        repeat (PROG + 5) @(negedge clk);
        expect_byte(8'hFF, "R7 pf refused");
        pf_flag = 1'b0;
        protect_mask = 5'b00010;
        stage(16'h0030, 3'd7, mk_data(8'h66));
        start_copy(16'h0030, 8'h07);
        repeat (PROG + 5) @(negedge clk);
        expect_byte(8'hFF, "R7 protect refused");
        protect_mask = 5'b0;
        stage(16'h0090, 3'd7, mk_data(8'h77));
        start_copy(16'h0090, 8'h07);
        repeat (PROG + 5) @(negedge clk);
        expect_byte(8'hFF, "R7 range refused");
        bus_rst();
        send(8'hF0); send(8'h28); send(8'h00);
        expect_byte(8'hFF, "R7 pf row untouched");
        bus_rst();
        send(8'hF0); send(8'h30); send(8'h00);
        expect_byte(8'hFF, "R7 protected row untouched");
    endtask

    task automatic t_rdmem;
        logic [63:0] d;
        d = mk_data(8'h90);
        stage(16'h0012, 3'd4, mk_data(8'h05));
        bus_rst();
        send(8'hF0); send(8'h8D); send(8'h00);
        expect_byte(d[5*8 +: 8], "R8 byte 8Dh");
        expect_byte(d[6*8 +: 8], "R8 byte 8Eh");
        expect_byte(d[7*8 +: 8], "R8 byte 8Fh");
        expect_byte(8'hFF, "R8 past end 1");
        expect_byte(8'hFF, "R8 past end 2");
        bus_rst();
        send(8'hF0); send(8'h00); send(8'h01);
        expect_byte(8'hFF, "R8 high address");
        read_sp(16'h0012, 3'd4, mk_data(8'h05), 1'b0, 1'b0); // R9
    endtask

    task automatic t_bus_reset;
        stage(16'h0040, 3'd1, mk_data(8'h23));
        bus_rst();
        send(8'h55); send(8'h40);
        bus_rst();
        send(8'hAA);
        expect_byte(8'h40, "R10 new command after reset");
    endtask

    task automatic t_unknown;
        bus_rst();
        send(8'h33);
        expect_byte(8'hFF, "R11 unknown read 1");
        send(8'hAA);
        expect_byte(8'hFF, "R11 unknown read 2");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rdsp();
        t_copy_ok(16'h0018, 8'h21);
        t_copy_ok(16'h0088, 8'h90);
        t_copy_mismatch();
        t_copy_denied();
        t_rdmem();
        t_bus_reset();
        t_unknown();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule